// File: doc/BRIEF.md
# Serial Transmitter with Sticky Ninth-Bit Register

This block sends asynchronous serial frames from a one-entry holding buffer through a shift register. Each frame is one low start bit, then the data bits least significant first, then an optional extra bit slot, then one high stop bit. Every bit lasts exactly one baud tick period. The start bit is the exception: it runs from the handover cycle to the next tick. The extra slot is present when nine-bit mode or parity is selected. With parity on it carries the generated parity bit. Otherwise it carries the value held in a separate ninth-bit register. That register is sticky: software writes it only when the value changes, and its content is captured into the shifter in the same cycle that the buffered byte moves across.

Software writes the ninth bit first and then the data byte. It watches `buf_empty` to refill the buffer and `tx_done` to learn that the line has gone quiet. The frame state machine has five states. IDLE holds the line high. START drives low. DATA shifts out the byte. EXTRA sends the slot bit. STOP drives high. The transitions are:
- IDLE->START on handover (enabled and buffer full).
- START->DATA on a tick.
- DATA->DATA on a tick while bits remain.
- DATA->EXTRA on the tick after the last data bit when the slot is present, otherwise DATA->STOP.
- EXTRA->STOP on a tick.
- STOP->IDLE on a tick.

Top module: `serial_tx9`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1 and `tx_done` is 1.
- R2: A frame with no extra slot has a start bit of 0, then data bits 0 to 7 in that order, then a stop bit of 1. After the start bit, each bit lasts one baud tick period.
- R3: With `nine_bit_mode`=1 and `parity_en`=0, the value of the ninth-bit register is sent after data bit 7 and before the stop bit.
- R4: The ninth-bit register keeps its value across frames. One write to it serves every later frame until it is written again.
- R5: The ninth-bit value is captured at handover. Writing it before the data byte pairs the new value with that byte. A write to it in the handover cycle reaches only later frames.
- R6: A data write makes `buf_empty` 0 after the next edge. A handover makes it 1 after that edge. A data write in the handover cycle sends the old byte and keeps the buffer full with the new byte.
- R7: `tx_done` goes to 0 at handover. It goes to 1 at the end of a stop bit only if the buffer is empty then. Between back-to-back frames it stays 0.
- R8: With `parity_en`=1 the extra slot is present in 8-bit mode and carries parity in place of the ninth-bit register. With `parity_odd`=0 the parity bit is the XOR of the data bits; with `parity_odd`=1 it is the inverse.
- R9: While `tx_en` is 0 no handover occurs. An idle line stays 1 and a buffered byte waits, with `buf_empty` at 0, until `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmitter enable |
| nine_bit_mode | input | 1 | 1 selects frames with a ninth bit |
| parity_en | input | 1 | 1 sends parity in the extra slot |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| data_wr | input | 1 | Data byte write strobe |
| data_in | input | 8 | Data byte to send |
| bit9_wr | input | 1 | Ninth-bit register write strobe |
| bit9_in | input | 1 | Ninth-bit value |
| txd | output | 1 | Serial line, high when idle |
| buf_empty | output | 1 | Holding buffer can take a byte |
| tx_done | output | 1 | No frame in progress and buffer empty |

## Verification
Two events can fall in the same cycle as the handover of the buffer to the shifter: a data write and a ninth-bit write. Each is provoked by holding the strobe into the edge where the idle machine takes the buffer. A data write there is judged by the frames that follow: the old byte must go out first, the new byte second, and `buf_empty` must stay 0 with `tx_done` low between the two frames. A ninth-bit write there is judged by its slot values: the frame in flight must carry the old value, and the next two frames must carry the new one.

// File: rtl/serial_tx9_pkg.sv
package serial_tx9_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_EXTRA = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_t;
endpackage

// File: rtl/tx9_hold_buffer.sv
module tx9_hold_buffer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic [DW-1:0] data_in,
    input  logic          bit9_wr,
    input  logic          bit9_in,
    input  logic          take,
    output logic [DW-1:0] hold_data,
    output logic          hold_bit9,
    output logic          hold_full
);
    // Sticky ninth bit: only a write changes it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_bit9 <= 1'b0;
        end else if (bit9_wr) begin
            hold_bit9 <= bit9_in;
        end
    end

    // A write in the take cycle refills the entry; the old byte leaves.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else begin
            if (data_wr) begin
                hold_data <= data_in;
                hold_full <= 1'b1;
            end else if (take) begin
                hold_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx9_parity_gen.sv
module tx9_parity_gen #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          odd,
    output logic          par
);
    logic [DW:0] chain;
    assign chain[0] = odd;
    for (genvar i = 0; i < DW; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ data[i];
    end
    assign par = chain[DW];
endmodule

// File: rtl/tx9_frame_fsm.sv
module tx9_frame_fsm
    import serial_tx9_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          tx_en,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic          slot_en,
    input  logic          slot_bit,
    output logic          take,
    output logic          txd,
    output logic          tx_done
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    tx_state_t     state, state_nx;
    logic [DW-1:0] shreg, shreg_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          extra_q, extra_nx;
    logic          slot_q, slot_nx;
    logic          done_q, done_nx;

    assign take = (state == ST_IDLE) && tx_en && hold_full;

    always_comb begin
        state_nx = state;
        shreg_nx = shreg;
        cnt_nx   = cnt;
        extra_q_nx_default();
        done_nx  = done_q;
        unique case (state)
            ST_IDLE: begin
                if (take) begin
                    state_nx = ST_START;
                    shreg_nx = hold_data;
                    extra_nx = slot_bit;
                    slot_nx  = slot_en;
                    done_nx  = 1'b0;
                end
            end
            ST_START: begin
                if (baud_tick) begin
                    state_nx = ST_DATA;
                    cnt_nx   = '0;
                end
            end
            ST_DATA: begin
                if (baud_tick) begin
                    shreg_nx = shreg >> 1;
                    if (cnt == LAST) begin
                        state_nx = slot_q ? ST_EXTRA : ST_STOP;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            ST_EXTRA: begin
                if (baud_tick) begin
                    state_nx = ST_STOP;
                end
            end
            ST_STOP: begin
                if (baud_tick) begin
                    state_nx = ST_IDLE;
                    if (!hold_full) begin
                        done_nx = 1'b1;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    function automatic void extra_q_nx_default();
        extra_nx = extra_q;
        slot_nx  = slot_q;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            cnt     <= '0;
            extra_q <= 1'b0;
            slot_q  <= 1'b0;
            done_q  <= 1'b1;
        end else begin
            state   <= state_nx;
            shreg   <= shreg_nx;
            cnt     <= cnt_nx;
            extra_q <= extra_nx;
            slot_q  <= slot_nx;
            done_q  <= done_nx;
        end
    end

    always_comb begin
        unique case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_EXTRA: txd = extra_q;
            default:  txd = 1'b1;
        endcase
    end

    assign tx_done = done_q;
endmodule

// File: rtl/serial_tx9.sv
module serial_tx9 #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          tx_en,
    input  logic          nine_bit_mode,
    input  logic          parity_en,
    input  logic          parity_odd,
    input  logic          data_wr,
    input  logic [DW-1:0] data_in,
    input  logic          bit9_wr,
    input  logic          bit9_in,
    output logic          txd,
    output logic          buf_empty,
    output logic          tx_done
);
    logic [DW-1:0] hold_data;
    logic          hold_bit9;
    logic          hold_full;
    logic          take;
    logic          par;
    logic          slot_en;
    logic          slot_bit;

    tx9_hold_buffer #(.DW(DW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (data_wr),
        .data_in   (data_in),
        .bit9_wr   (bit9_wr),
        .bit9_in   (bit9_in),
        .take      (take),
        .hold_data (hold_data),
        .hold_bit9 (hold_bit9),
        .hold_full (hold_full)
    );

    tx9_parity_gen #(.DW(DW)) u_par (
        .data (hold_data),
        .odd  (parity_odd),
        .par  (par)
    );

    // Parity, when on, takes the extra slot and overrides the sticky bit.
    assign slot_en  = nine_bit_mode | parity_en;
    assign slot_bit = parity_en ? par : hold_bit9;

    tx9_frame_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .slot_en   (slot_en),
        .slot_bit  (slot_bit),
        .take      (take),
        .txd       (txd),
        .tx_done   (tx_done)
    );

    assign buf_empty = ~hold_full;
endmodule

// File: rtl/serial_tx9_checker.sv
module serial_tx9_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic data_wr,
    input logic txd,
    input logic buf_empty,
    input logic tx_done
);
    // R6: a write always leaves the buffer full.
    p_write_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !buf_empty);

    // R6: the buffer empties only by handover, which starts a frame.
    p_empty_means_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> !txd);

    // R7: completion never coexists with an active line.
    p_done_line_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd);

    // R7: completion rises only if the buffer was empty at the stop end.
    p_done_needs_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(buf_empty));

    // R9: disabled transmitter keeps a loaded buffer.
    p_disabled_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !buf_empty) |=> !buf_empty);
endmodule

bind serial_tx9 serial_tx9_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .data_wr   (data_wr),
    .txd       (txd),
    .buf_empty (buf_empty),
    .tx_done   (tx_done)
);

// File: tb/test_serial_tx9.sv
`timescale 1ns/1ps
module test_serial_tx9;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b1;
    logic       nine_bit_mode = 1'b0;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_in = '0;
    logic       bit9_wr = 1'b0;
    logic       bit9_in = 1'b0;
    logic       txd, buf_empty, tx_done;

    int n_chk = 0;
    int n_bad = 0;
    logic last_tick = 1'b0;
    int div = 0;

    always #4 clk = ~clk;

    serial_tx9 i_serial_tx9 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .nine_bit_mode(nine_bit_mode), .parity_en(parity_en), .parity_odd(parity_odd),
        .data_wr(data_wr), .data_in(data_in), .bit9_wr(bit9_wr), .bit9_in(bit9_in),
        .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
    );

    // Tick generator; last_tick records the tick seen at the previous edge.
    always @(negedge clk) begin
        last_tick <= baud_tick;
        div       <= (div == TICK_DIV - 1) ? 0 : div + 1;
        baud_tick <= (div == TICK_DIV - 1);
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic write_data(input logic [7:0] d);
        @(negedge clk);
        data_wr = 1'b1; data_in = d;
        @(negedge clk);
        data_wr = 1'b0;
        #1;
    endtask

    task automatic write_bit9(input logic b);
        @(negedge clk);
        bit9_wr = 1'b1; bit9_in = b;
        @(negedge clk);
        bit9_wr = 1'b0;
        #1;
    endtask

    // Capture one frame; returns data byte, slot bit and stop bit.
    task automatic grab(input bit has_slot, input bit skip_start,
                        output logic [7:0] d, output logic nb, output logic stp);
        if (!skip_start) begin
            forever begin
                step();
                if (txd == 1'b0) break;
            end
        end
        for (int i = 0; i < 8; i++) begin
            forever begin
                step();
                if (last_tick) break;
            end
            d[i] = txd;
        end
        nb = 1'b0;
        if (has_slot) begin
            forever begin
                step();
                if (last_tick) break;
            end
            nb = txd;
        end
        forever begin
            step();
            if (last_tick) break;
        end
        stp = txd;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4 * TICK_DIV; i++) begin
            step();
            if (tx_done) break;
        end
    endtask

    task automatic t_reset();
        chk("R1 txd", int'(txd), 1);
        chk("R1 buf_empty", int'(buf_empty), 1);
        chk("R1 tx_done", int'(tx_done), 1);
    endtask

    task automatic t_plain_frame();
        logic [7:0] d; logic nb, stp;
        nine_bit_mode = 1'b0; parity_en = 1'b0;
        write_data(8'hA6);
        chk("R6 empty clears", int'(buf_empty), 0);
        grab(1'b0, 1'b0, d, nb, stp);
        chk("R2 data", int'(d), 8'hA6);
        chk("R2 stop", int'(stp), 1);
        wait_done();
        chk("R7 done after frame", int'(tx_done), 1);
        chk("R6 empty after handover", int'(buf_empty), 1);
    endtask

    task automatic t_ninth_coherent();
        logic [7:0] d; logic nb, stp;
        nine_bit_mode = 1'b1; parity_en = 1'b0;
        write_bit9(1'b1);
        write_data(8'h3C);
        grab(1'b1, 1'b0, d, nb, stp);
        chk("R3 data", int'(d), 8'h3C);
        chk("R5 ninth paired", int'(nb), 1);
        chk("R3 stop", int'(stp), 1);
        wait_done();
        write_data(8'h81);
        grab(1'b1, 1'b0, d, nb, stp);
        chk("R4 sticky ninth", int'(nb), 1);
        chk("R4 data", int'(d), 8'h81);
        wait_done();
    endtask

    task automatic t_ninth_collision();
        logic [7:0] d; logic nb, stp;
        nine_bit_mode = 1'b1; parity_en = 1'b0;
        write_bit9(1'b0);
        @(negedge clk);
        data_wr = 1'b1; data_in = 8'h55;
        @(negedge clk);
        data_wr = 1'b0; bit9_wr = 1'b1; bit9_in = 1'b1;
        @(negedge clk);
        bit9_wr = 1'b0;
        #1;
        chk("R5 start at handover", int'(txd), 0);
        grab(1'b1, 1'b1, d, nb, stp);
        chk("R5 old ninth kept", int'(nb), 0);
        chk("R5 data", int'(d), 8'h55);
        wait_done();
        write_data(8'hF0);
        grab(1'b1, 1'b0, d, nb, stp);
        chk("R5 new ninth next frame", int'(nb), 1);
        wait_done();
        write_data(8'h0F);
        grab(1'b1, 1'b0, d, nb, stp);
        chk("R4 ninth still set", int'(nb), 1);
        wait_done();
    endtask

    task automatic t_data_collision();
        logic [7:0] d; logic nb, stp;
        int done_hi;
        nine_bit_mode = 1'b0; parity_en = 1'b0;
        @(negedge clk);
        data_wr = 1'b1; data_in = 8'h12;
        @(negedge clk);
        data_in = 8'hED;
        @(negedge clk);
        data_wr = 1'b0;
        #1;
        chk("R6 buffer stays full", int'(buf_empty), 0);
        chk("R6 first frame started", int'(txd), 0);
        chk("R7 done low at handover", int'(tx_done), 0);
        grab(1'b0, 1'b1, d, nb, stp);
        chk("R6 old byte first", int'(d), 8'h12);
        done_hi = 0;
        forever begin
            step();
            if (tx_done) done_hi++;
            if (txd == 1'b0) break;
        end
        chk("R7 done low between frames", done_hi, 0);
        grab(1'b0, 1'b1, d, nb, stp);
        chk("R6 new byte second", int'(d), 8'hED);
        wait_done();
        chk("R7 done after pair", int'(tx_done), 1);
    endtask

    task automatic t_parity();
        logic [7:0] d; logic nb, stp;
        nine_bit_mode = 1'b0; parity_en = 1'b1; parity_odd = 1'b0;
        write_bit9(1'b0);
        write_data(8'h07);
        grab(1'b1, 1'b0, d, nb, stp);
        chk("R8 even parity", int'(nb), 1);
        chk("R8 data", int'(d), 8'h07);
        chk("R8 stop", int'(stp), 1);
        wait_done();
        parity_odd = 1'b1;
        write_data(8'h07);
        grab(1'b1, 1'b0, d, nb, stp);
        chk("R8 odd parity", int'(nb), 0);
        wait_done();
        parity_odd = 1'b0;
        write_data(8'hC3);
        grab(1'b1, 1'b0, d, nb, stp);
        chk("R8 even parity four ones", int'(nb), 0);
        wait_done();
        parity_en = 1'b0;
    endtask

    task automatic t_disabled();
        logic [7:0] d; logic nb, stp;
        int low_seen;
        nine_bit_mode = 1'b0;
        tx_en = 1'b0;
        write_data(8'h9B);
        low_seen = 0;
        for (int i = 0; i < 6 * TICK_DIV; i++) begin
            step();
            if (!txd) low_seen++;
        end
        chk("R9 line idle", low_seen, 0);
        chk("R9 buffer held", int'(buf_empty), 0);
        @(negedge clk);
        tx_en = 1'b1;
        grab(1'b0, 1'b0, d, nb, stp);
        chk("R9 byte sent after enable", int'(d), 8'h9B);
        wait_done();
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_plain_frame();
        t_ninth_coherent();
        t_ninth_collision();
        t_data_collision();
        t_parity();
        t_disabled();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule